// File: doc/BRIEF.md
# Debug Event Qualifier

This block decides whether an address-comparator hit should become a debug event. Breakpoint and watchpoint comparators each come with their own control word. On a start strobe the block walks the selected set, one comparator per clock cycle. For each comparator it checks the enable bit, the security-state filter, the privilege filter and the optional link to a context-ID breakpoint. It stops at the first comparator that qualifies.

The result comes with a one-cycle done strobe and is then held until the next start. A global monitor-debug enable and a debug-exceptions-allowed input gate the whole scan. When either of them is low, the block reports "no event" without scanning.

The control logic is a three-state machine:

- **IDLE** waits for start.
  - The transition *launch* goes to SCAN when both gates are high.
  - The transition *gated* goes straight to REPORT when either gate is low.
- **SCAN** evaluates the comparator at the scan index.
  - The transition *hit-found* goes to REPORT when that comparator qualifies.
  - The transition *exhausted* goes to REPORT when the last comparator fails.
  - Otherwise the transition *advance* stays in SCAN and moves the index up by one.
- **REPORT** raises done for one cycle. The transition *retire* returns to IDLE.

Every input except start must be held stable while the block is busy.

Top module: `dbg_event_qualifier`

## Requirements
- R1: After reset, busy, done and match are 0 and match_idx is 0.
- R2: If start is sampled in IDLE while mon_dbg_en or dbg_allowed is 0, done is high in the first cycle after that edge, and match is 0.
- R3: With both gates high, the scan visits indices 0 upward, one per cycle.
  - If index k is the lowest qualifying index, done is high k+1 cycles after the start edge, match is 1 and match_idx equals k.
  - If no index qualifies, done is high after N cycles, where N is NUM_BRK or NUM_WPT, and match is 0.
  - done lasts exactly one cycle, and match and match_idx hold until the next start.
- R4: A comparator qualifies only when its hit input is 1 and bit 0 of its control word (enable) is 1.
- R5: Control bits 15:14 form the security filter.
  - Value 0 passes in either state.
  - Value 2 passes only when secure is 1.
  - Values 1 and 3 pass only when secure is 0.
- R6: The privilege filter depends on the effective level.
  - At level 2 or 3 it requires control bit 13.
  - At level 1 it requires control bit 1.
  - At level 0 it requires control bit 2.
- R7: For a watchpoint scan with unpriv=1, the effective level for R6 is 0. For a breakpoint scan, unpriv has no effect.
- R8: Link requests depend on the scan kind.
  - A watchpoint requests a link when control bit 20 is 1.
  - For a breakpoint, the type field in bits 23:20 decides. Type 0 is unlinked, type 1 requests a link, and any other type never qualifies.
  - A requested link must pass R9 and R10.
- R9: The linked index is control bits 19:16. It must lie in [NUM_BRK-CTX_BRK, NUM_BRK-1], or the link fails.
- R10: The link target is the breakpoint at the linked index. The link passes only when all of these hold:
  - the target's enable bit is set;
  - the target's type field (bits 23:20) is 3;
  - cur_el is below 2;
  - ctx_id equals the low 32 bits of the target's value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (sampled in IDLE) |
| scan_wp | input | 1 | 1 = scan watchpoints, 0 = scan breakpoints |
| mon_dbg_en | input | 1 | Global monitor-debug enable |
| dbg_allowed | input | 1 | Debug exceptions currently permitted |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state, 1 = secure |
| unpriv | input | 1 | Access is an unprivileged load/store |
| ctx_id | input | 32 | Current context ID |
| brk_hit | input | NUM_BRK | Breakpoint address-comparator hits |
| brk_ctl | input | NUM_BRK*32 | Breakpoint control words, index i at [32i+31:32i] |
| brk_val | input | NUM_BRK*64 | Breakpoint value registers, index i at [64i+63:64i] |
| wpt_hit | input | NUM_WPT | Watchpoint address-comparator hits |
| wpt_ctl | input | NUM_WPT*32 | Watchpoint control words |
| busy | output | 1 | Not in IDLE |
| done | output | 1 | One-cycle completion strobe |
| match | output | 1 | A comparator qualified |
| match_idx | output | IDX_W | Index of the qualifying comparator |

## Verification
The bench targets several corner cases, each chosen because a specific bug would show up in it:

- **Exact scan latency.** Scans are timed, so an off-by-one counter would either skip the last comparator or run past it, and the done cycle would move.
- **Early stop.** Two qualifying comparators are present at once. A design that does not stop early would report the higher index.
- **Unprivileged accesses.** A watchpoint scan with unpriv set must use the level-0 privilege bit, and a breakpoint scan must ignore unpriv. Getting this wrong flips the match.
- **Linked context-ID checks.** The bench tries a link index just below and just above the context-aware window. It also tries a disabled target, a target of the wrong type, a mismatching context ID, and a level-2 access. A check that leaks through any of these reports a false event.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
    localparam int CTL_W = 32;
    localparam int VAL_W = 64;
    localparam int CTX_W = 32;

    // bit positions inside a control word (decoded by several blocks)
    localparam int B_EN   = 0;
    localparam int B_PRIV = 1;   // 2 bits
    localparam int B_HIGH = 13;
    localparam int B_SEC  = 14;  // 2 bits
    localparam int B_LINK = 16;  // 4 bits
    localparam int B_TYPE = 20;  // 4 bits

    localparam logic [3:0] TYPE_ADDR   = 4'd0;
    localparam logic [3:0] TYPE_LINKED = 4'd1;
    localparam logic [3:0] TYPE_CTXID  = 4'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/dbgq_mode_filter.sv
module dbgq_mode_filter (
    input  logic [1:0] sec_field,
    input  logic [1:0] priv_field,
    input  logic       high_bit,
    input  logic [1:0] cur_el,
    input  logic       secure,
    input  logic       unpriv,
    input  logic       is_wp,
    output logic       mode_ok
);
    logic [1:0] eff_el;
    logic       sec_ok;
    logic       priv_ok;

    always_comb begin
        eff_el = (is_wp && unpriv) ? 2'd0 : cur_el;

        unique case (sec_field)
            2'd0:    sec_ok = 1'b1;
            2'd2:    sec_ok = secure;
            default: sec_ok = !secure;
        endcase

        if (eff_el >= 2'd2)
            priv_ok = high_bit;
        else if (eff_el == 2'd1)
            priv_ok = priv_field[0];
        else
            priv_ok = priv_field[1];

        mode_ok = sec_ok && priv_ok;
    end
endmodule

// File: rtl/dbgq_link_check.sv
module dbgq_link_check
    import dbgq_pkg::*;
#(
    parameter int NUM_BRK = 6,
    parameter int CTX_BRK = 2
) (
    input  logic [3:0]               link_num,
    input  logic [1:0]               cur_el,
    input  logic [CTX_W-1:0]         ctx_id,
    input  logic [NUM_BRK*CTL_W-1:0] brk_ctl,
    input  logic [NUM_BRK*VAL_W-1:0] brk_val,
    output logic                     link_ok
);
    localparam int FIRST_CTX = NUM_BRK - CTX_BRK;
    localparam int LAST_BRK  = NUM_BRK - 1;

    logic [CTL_W-1:0] ctl_a [NUM_BRK];
    logic [VAL_W-1:0] val_a [NUM_BRK];

    genvar g;
    generate
        for (g = 0; g < NUM_BRK; g++) begin : g_unpack
            assign ctl_a[g] = brk_ctl[g*CTL_W +: CTL_W];
            assign val_a[g] = brk_val[g*VAL_W +: VAL_W];
        end
    endgenerate

    logic [CTL_W-1:0] tgt_ctl;
    logic [VAL_W-1:0] tgt_val;
    logic             in_window;
    int               num_i;

    always_comb begin
        num_i   = int'(link_num);
        tgt_ctl = '0;
        tgt_val = '0;
        for (int j = 0; j < NUM_BRK; j++) begin
            if (num_i == j) begin
                tgt_ctl = ctl_a[j];
                tgt_val = val_a[j];
            end
        end
        in_window = (num_i >= FIRST_CTX) && (num_i <= LAST_BRK);
        link_ok   = in_window
                 && tgt_ctl[B_EN]
                 && (tgt_ctl[B_TYPE +: 4] == TYPE_CTXID)
                 && (cur_el < 2'd2)
                 && (tgt_val[CTX_W-1:0] == ctx_id);
    end

    logic unused_tgt;
    assign unused_tgt = ^{tgt_ctl[CTL_W-1:B_TYPE+4], tgt_ctl[B_TYPE-1:1],
                          tgt_val[VAL_W-1:CTX_W]};
endmodule

// File: rtl/dbgq_scan_fsm.sv
module dbgq_scan_fsm
    import dbgq_pkg::*;
#(
    parameter int NUM_BRK = 6,
    parameter int NUM_WPT = 4,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             scan_wp,
    input  logic             gate_ok,
    input  logic             cur_qual,
    output logic             busy,
    output logic             done,
    output logic             match,
    output logic [IDX_W-1:0] match_idx,
    output logic [IDX_W-1:0] scan_idx,
    output logic             scan_kind
);
    localparam logic [IDX_W-1:0] LAST_BRK = IDX_W'(NUM_BRK - 1);
    localparam logic [IDX_W-1:0] LAST_WPT = IDX_W'(NUM_WPT - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             kind_q;
    logic             match_q;
    logic [IDX_W-1:0] midx_q;
    logic [IDX_W-1:0] last_idx;
    logic             at_last;

    assign last_idx = kind_q ? LAST_WPT : LAST_BRK;
    assign at_last  = (idx_q == last_idx);

    // next-state: launch / gated / hit-found / exhausted / advance / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = gate_ok ? ST_SCAN : ST_REPORT;
            ST_SCAN:   if (cur_qual || at_last) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            kind_q  <= 1'b0;
            match_q <= 1'b0;
            midx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= '0;
                        kind_q  <= scan_wp;
                        match_q <= 1'b0;
                        midx_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (cur_qual) begin
                        match_q <= 1'b1;
                        midx_q  <= idx_q;
                    end else if (!at_last) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_REPORT);
        match     = match_q;
        match_idx = midx_q;
        scan_idx  = idx_q;
        scan_kind = kind_q;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (idx_q <= last_idx)); // R3
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(match_q) && $stable(midx_q))); // R3
    AST_GATED_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !gate_ok) |=> (state_q == ST_REPORT && !match_q)); // R2
    AST_MATCH_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT && match_q) |-> (midx_q <= last_idx)); // R3
endmodule

// File: rtl/dbg_event_qualifier.sv
module dbg_event_qualifier
    import dbgq_pkg::*;
#(
    parameter int NUM_BRK = 6,
    parameter int NUM_WPT = 4,
    parameter int CTX_BRK = 2,
    localparam int MAX_N  = (NUM_BRK > NUM_WPT) ? NUM_BRK : NUM_WPT,
    localparam int IDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     scan_wp,
    input  logic                     mon_dbg_en,
    input  logic                     dbg_allowed,
    input  logic [1:0]               cur_el,
    input  logic                     secure,
    input  logic                     unpriv,
    input  logic [CTX_W-1:0]         ctx_id,
    input  logic [NUM_BRK-1:0]       brk_hit,
    input  logic [NUM_BRK*CTL_W-1:0] brk_ctl,
    input  logic [NUM_BRK*VAL_W-1:0] brk_val,
    input  logic [NUM_WPT-1:0]       wpt_hit,
    input  logic [NUM_WPT*CTL_W-1:0] wpt_ctl,
    output logic                     busy,
    output logic                     done,
    output logic                     match,
    output logic [IDX_W-1:0]         match_idx
);
    logic [CTL_W-1:0] brk_ctl_a [NUM_BRK];
    logic [CTL_W-1:0] wpt_ctl_a [NUM_WPT];

    genvar g;
    generate
        for (g = 0; g < NUM_BRK; g++) begin : g_brk
            assign brk_ctl_a[g] = brk_ctl[g*CTL_W +: CTL_W];
        end
        for (g = 0; g < NUM_WPT; g++) begin : g_wpt
            assign wpt_ctl_a[g] = wpt_ctl[g*CTL_W +: CTL_W];
        end
    endgenerate

    logic [IDX_W-1:0] scan_idx;
    logic             scan_kind;
    logic [CTL_W-1:0] sel_ctl;
    logic             sel_hit;

    always_comb begin
        sel_ctl = '0;
        sel_hit = 1'b0;
        if (scan_kind) begin
            for (int i = 0; i < NUM_WPT; i++) begin
                if (scan_idx == IDX_W'(i)) begin
                    sel_ctl = wpt_ctl_a[i];
                    sel_hit = wpt_hit[i];
                end
            end
        end else begin
            for (int i = 0; i < NUM_BRK; i++) begin
                if (scan_idx == IDX_W'(i)) begin
                    sel_ctl = brk_ctl_a[i];
                    sel_hit = brk_hit[i];
                end
            end
        end
    end

    logic [3:0] sel_type;
    logic       mode_ok;
    logic       link_ok;
    logic       link_gate;
    logic       cur_qual;
    logic       gate_ok;

    assign sel_type = sel_ctl[B_TYPE +: 4];
    assign gate_ok  = mon_dbg_en && dbg_allowed;

    dbgq_mode_filter i_mode (
        .sec_field  (sel_ctl[B_SEC +: 2]),
        .priv_field (sel_ctl[B_PRIV +: 2]),
        .high_bit   (sel_ctl[B_HIGH]),
        .cur_el     (cur_el),
        .secure     (secure),
        .unpriv     (unpriv),
        .is_wp      (scan_kind),
        .mode_ok    (mode_ok)
    );

    dbgq_link_check #(
        .NUM_BRK (NUM_BRK),
        .CTX_BRK (CTX_BRK)
    ) i_link (
        .link_num (sel_ctl[B_LINK +: 4]),
        .cur_el   (cur_el),
        .ctx_id   (ctx_id),
        .brk_ctl  (brk_ctl),
        .brk_val  (brk_val),
        .link_ok  (link_ok)
    );

    always_comb begin
        if (scan_kind)
            link_gate = sel_ctl[B_TYPE] ? link_ok : 1'b1;
        else if (sel_type == TYPE_ADDR)
            link_gate = 1'b1;
        else if (sel_type == TYPE_LINKED)
            link_gate = link_ok;
        else
            link_gate = 1'b0;
        cur_qual = sel_hit && sel_ctl[B_EN] && mode_ok && link_gate;
    end

    dbgq_scan_fsm #(
        .NUM_BRK (NUM_BRK),
        .NUM_WPT (NUM_WPT),
        .IDX_W   (IDX_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .scan_wp   (scan_wp),
        .gate_ok   (gate_ok),
        .cur_qual  (cur_qual),
        .busy      (busy),
        .done      (done),
        .match     (match),
        .match_idx (match_idx),
        .scan_idx  (scan_idx),
        .scan_kind (scan_kind)
    );

    logic unused_ctl;
    assign unused_ctl = ^{sel_ctl[CTL_W-1:B_TYPE+4], sel_ctl[B_HIGH-1:B_PRIV+2]};

    AST_LINK_LOW_EL: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |-> (cur_el < 2'd2)); // R10
    AST_QUAL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_qual) |-> (sel_hit && sel_ctl[B_EN])); // R4
    AST_SEC_ONLY_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_ok && sel_ctl[B_SEC +: 2] == 2'd2) |-> secure); // R5
    AST_SEC_ONLY_NONSEC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_ok && sel_ctl[B_SEC]) |-> !secure); // R5
endmodule

// File: tb/test_dbg_event_qualifier.sv
module test_dbg_event_qualifier;
    localparam int NB = 6;
    localparam int NW = 4;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, scan_wp = 1'b0, mon_dbg_en = 1'b1, dbg_allowed = 1'b1;
    logic [1:0] cur_el = 2'd1;
    logic secure = 1'b0, unpriv = 1'b0;
    logic [31:0] ctx_id = 32'h1234_5678;
    logic [NB-1:0] brk_hit = '0;
    logic [NB*32-1:0] brk_ctl = '0;
    logic [NB*64-1:0] brk_val = '0;
    logic [NW-1:0] wpt_hit = '0;
    logic [NW*32-1:0] wpt_ctl = '0;
    logic busy, done, match;
    logic [2:0] match_idx;

    always #10 clk = ~clk;

    dbg_event_qualifier #(.NUM_BRK(NB), .NUM_WPT(NW), .CTX_BRK(NC)) i_dbg_event_qualifier (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_wp(scan_wp),
        .mon_dbg_en(mon_dbg_en), .dbg_allowed(dbg_allowed), .cur_el(cur_el),
        .secure(secure), .unpriv(unpriv), .ctx_id(ctx_id),
        .brk_hit(brk_hit), .brk_ctl(brk_ctl), .brk_val(brk_val),
        .wpt_hit(wpt_hit), .wpt_ctl(wpt_ctl),
        .busy(busy), .done(done), .match(match), .match_idx(match_idx));

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctl(input logic en, input logic [1:0] pac, input logic hmc,
                                          input logic [1:0] ssc, input logic [3:0] lbn,
                                          input logic [3:0] top);
        return {8'b0, top, lbn, ssc, hmc, 10'b0, pac, en};
    endfunction

    typedef struct packed {
        logic       kind;
        logic [2:0] idx;
        logic [1:0] ssc;
        logic       hmc;
        logic [1:0] pac;
        logic [3:0] lbn;
        logic [3:0] top;
        logic [1:0] el;
        logic       sec;
        logic       unp;
        logic       bad;
        logic       exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 2'd0, 1'b0, 2'b01, 4'd0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 el1
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b10, 4'd0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b10, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 el0
        '{1'b0, 3'd2, 2'd0, 1'b0, 2'b11, 4'd0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 el2
        '{1'b0, 3'd2, 2'd0, 1'b1, 2'b00, 4'd0, 4'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 el3
        '{1'b0, 3'd0, 2'd2, 1'b0, 2'b11, 4'd0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b0, 3'd0, 2'd2, 1'b0, 2'b11, 4'd0, 4'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
        '{1'b0, 3'd3, 2'd1, 1'b0, 2'b11, 4'd0, 4'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b0, 3'd3, 2'd3, 1'b0, 2'b11, 4'd0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
        '{1'b1, 3'd0, 2'd0, 1'b0, 2'b10, 4'd0, 4'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1}, // R7
        '{1'b1, 3'd0, 2'd0, 1'b0, 2'b01, 4'd0, 4'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
        '{1'b1, 3'd3, 2'd0, 1'b0, 2'b01, 4'd0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b11, 4'd4, 4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R10
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b11, 4'd4, 4'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0}, // R10
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b11, 4'd5, 4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b11, 4'd3, 4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 3'd1, 2'd0, 1'b0, 2'b11, 4'd6, 4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 3'd1, 2'd0, 1'b1, 2'b11, 4'd4, 4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        '{1'b1, 3'd2, 2'd0, 1'b0, 2'b10, 4'd4, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        '{1'b1, 3'd2, 2'd0, 1'b0, 2'b10, 4'd4, 4'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8
        '{1'b0, 3'd0, 2'd0, 1'b0, 2'b11, 4'd4, 4'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b1, 3'd1, 2'd0, 1'b0, 2'b01, 4'd4, 4'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1}, // R8
        '{1'b0, 3'd0, 2'd0, 1'b0, 2'b01, 4'd0, 4'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1}  // R7
    };

    task automatic defaults();
        brk_hit = '0; wpt_hit = '0; brk_ctl = '0; wpt_ctl = '0; brk_val = '0;
        brk_ctl[3*32 +: 32] = mkctl(1'b1, 2'b00, 1'b0, 2'd0, 4'd0, 4'd3);
        brk_val[3*64 +: 64] = 64'h0000_0000_1234_5678;
        brk_ctl[4*32 +: 32] = mkctl(1'b1, 2'b00, 1'b0, 2'd0, 4'd0, 4'd3);
        brk_val[4*64 +: 64] = 64'hFFFF_0000_1234_5678;
        brk_ctl[5*32 +: 32] = mkctl(1'b0, 2'b00, 1'b0, 2'd0, 4'd0, 4'd3);
        brk_val[5*64 +: 64] = 64'h0000_0000_1234_5678;
        mon_dbg_en = 1'b1; dbg_allowed = 1'b1; unpriv = 1'b0; secure = 1'b0;
        cur_el = 2'd1; ctx_id = 32'h1234_5678;
    endtask

    task automatic run_scan(input logic kind, output int lat);
        scan_wp = kind;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        defaults();
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 match", match, 0);
        chk("R1 match_idx", match_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = TBL[v];
            defaults();
            cur_el = t.el; secure = t.sec; unpriv = t.unp;
            ctx_id = t.bad ? 32'hDEAD_BEEF : 32'h1234_5678;
            if (t.kind) begin
                wpt_ctl[t.idx*32 +: 32] = mkctl(1'b1, t.pac, t.hmc, t.ssc, t.lbn, t.top);
                wpt_hit[t.idx] = 1'b1;
            end else begin
                brk_ctl[t.idx*32 +: 32] = mkctl(1'b1, t.pac, t.hmc, t.ssc, t.lbn, t.top);
                brk_hit[t.idx] = 1'b1;
            end
            run_scan(t.kind, lat);
            chk($sformatf("R3 vec%0d match", v), match, t.exp);
            chk($sformatf("R3 vec%0d latency", v), lat,
                t.exp ? int'(t.idx) + 1 : (t.kind ? NW : NB));
            if (t.exp) chk($sformatf("R3 vec%0d idx", v), match_idx, t.idx);
            @(negedge clk);
        end

        // R2: global enable low
        defaults();
        brk_ctl[0 +: 32] = mkctl(1'b1, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        brk_hit[0] = 1'b1;
        mon_dbg_en = 1'b0;
        run_scan(1'b0, lat);
        chk("R2 mon_en latency", lat, 0);
        chk("R2 mon_en match", match, 0);
        @(negedge clk);
        mon_dbg_en = 1'b1; dbg_allowed = 1'b0;
        run_scan(1'b0, lat);
        chk("R2 allowed latency", lat, 0);
        chk("R2 allowed match", match, 0);
        @(negedge clk);

        // R3: early stop at lowest qualifying index, result held
        defaults();
        brk_ctl[1*32 +: 32] = mkctl(1'b1, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        brk_ctl[2*32 +: 32] = mkctl(1'b1, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        brk_hit[1] = 1'b1; brk_hit[2] = 1'b1;
        run_scan(1'b0, lat);
        chk("R3 early latency", lat, 2);
        chk("R3 early idx", match_idx, 1);
        @(negedge clk);
        chk("R3 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk("R3 match held", match, 1);
        chk("R3 idx held", match_idx, 1);

        // R3: last index qualifies
        defaults();
        brk_ctl[5*32 +: 32] = mkctl(1'b1, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        brk_hit[5] = 1'b1;
        run_scan(1'b0, lat);
        chk("R3 last latency", lat, NB);
        chk("R3 last match", match, 1);
        chk("R3 last idx", match_idx, NB - 1);
        @(negedge clk);

        // R4: qualifying control but no hit; hit but enable clear
        defaults();
        wpt_ctl[1*32 +: 32] = mkctl(1'b1, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        run_scan(1'b1, lat);
        chk("R4 no hit match", match, 0);
        chk("R4 no hit latency", lat, NW);
        @(negedge clk);
        wpt_ctl[1*32 +: 32] = mkctl(1'b0, 2'b01, 1'b0, 2'd0, 4'd0, 4'd0);
        wpt_hit[1] = 1'b1;
        run_scan(1'b1, lat);
        chk("R4 disabled match", match, 0);
        @(negedge clk);

        // R10: link target of wrong type
        defaults();
        brk_ctl[4*32 +: 32] = mkctl(1'b1, 2'b00, 1'b0, 2'd0, 4'd0, 4'd5);
        brk_ctl[1*32 +: 32] = mkctl(1'b1, 2'b11, 1'b0, 2'd0, 4'd4, 4'd1);
        brk_hit[1] = 1'b1;
        run_scan(1'b0, lat);
        chk("R10 target type match", match, 0);
        @(negedge clk);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule